// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block keeps one window descriptor per flash chip select and uses them to steer memory-mapped flash accesses. Each descriptor places a window, in 8 MB granules, inside the controller's overall flash aperture. A bus address presented on the lookup port is resolved into the chip select whose window contains it and the byte offset inside that window. An access port takes a chip select and a raw offset and folds the offset back into that chip select's window.

Descriptor writes are checked before they are stored. The first chip select always starts at the aperture base, whatever start is written. A window lying entirely outside the aperture is refused and the old descriptor is kept. A window that is misaligned to its own size, or that collides with another chip select's window, is stored but reported. Four registered status flags report the outcome of the most recent write.

Top module: `segment_window_decoder`

## Requirements
- R1: Reset loads chip select 0 with the window [base, base+64 MB) and each following chip select with the next 32 MB window (defaults base unit 0x40, i.e. byte address 0x2000_0000, and an aperture of 32 units). All four status flags are 0 during and after reset.
- R2: A write value carries the end unit in bits [31:24] and the start unit in bits [23:16]. A unit is address bits [30:23] (8 MB). Bits [15:0] are discarded, and the stored descriptor compares as if they were zero.
- R3: A write to chip select 0 whose start unit differs from the base unit is stored with the start replaced by the base unit and the end kept. `st_fixed` then reads 1.
- R4: A write whose end unit is at or below the base unit, or whose (corrected) start unit is greater than base unit + aperture units, is refused. The descriptor keeps its old value and `st_reject` reads 1, with `st_misalign` and `st_overlap` at 0.
- R5: Window length is end − start when end > start, else 0. An accepted write with nonzero length whose start is not a multiple of its length sets `st_misalign`, and is still stored.
- R6: An accepted write sets `st_overlap` when, for some other chip select k, new start < end(k) and new end > start(k).
- R7: A write whose bits [31:16] equal the stored descriptor, or whose index names no chip select, changes nothing and clears all four flags.
- R8: The flags are registered. They take the result of a write on the clock edge that samples it, and they hold between writes.
- R9: Lookup is combinational. With address bit 31 clear and address unit in [start, end) of a chip select, `lk_hit`=1 and `lk_offset` = address − start×8 MB. Otherwise `lk_hit`=0, `lk_cs`=0 and `lk_offset`=0.
- R10: When several windows contain the address, the lowest-numbered chip select is reported.
- R11: The access port uses the length of chip select `acc_cs`, taken as 0 for an index that names no chip select. An offset below the length passes unchanged with `acc_oor`=0. An offset at or above a nonzero length gives `acc_oor`=1 and the offset modulo the length. A zero length gives `acc_oor`=1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_cs | input | CS_W | Chip select being written |
| wr_data | input | 32 | Descriptor value (end, start, zero) |
| st_fixed | output | 1 | Last write had its chip-select-0 start corrected |
| st_reject | output | 1 | Last write was refused |
| st_misalign | output | 1 | Last stored window not aligned to its length |
| st_overlap | output | 1 | Last stored window collides with another |
| lk_addr | input | 32 | Absolute bus address to resolve |
| lk_hit | output | 1 | Address falls in some window |
| lk_cs | output | CS_W | Winning chip select |
| lk_offset | output | 32 | Offset inside the winning window |
| acc_cs | input | CS_W | Chip select for the access fold |
| acc_offset | input | 32 | Raw access offset |
| acc_wrapped | output | 32 | Offset folded into the window |
| acc_oor | output | 1 | Raw offset was outside the window |

## Verification
Lookups are driven at addresses on window edges (first byte, last byte, first byte past the end), below and above the aperture, and with bit 31 set. These patterns separate an off-by-one window compare from a correct one and expose a wrong priority when two windows stack. Writes are chosen so that each legality outcome occurs alone and in combination: a corrected start that then misaligns and overlaps, refusals on either side of the aperture, and a repeat write that differs only in the discarded low bits. Access offsets straddle exactly one and several window lengths and zero-length windows, which tells a true modulo apart from a single subtraction or a power-of-two mask. A long random phase then mixes all three ports against the behavioural model every cycle.

// File: rtl/segwin_pkg.sv
package segwin_pkg;

   // Address bit of the least significant window unit (8 MB granules).
   localparam int unsigned UNIT_LSB = 23;
   localparam int unsigned FIELD_W  = 8;

   typedef logic [FIELD_W-1:0] unit_t;

   // Descriptor as stored: end unit above start unit.
   typedef struct packed {
      unit_t end_u;
      unit_t start_u;
   } seg_t;

   // Window length in units; empty or inverted windows have length zero.
   function automatic unit_t seg_len(seg_t s);
      return (s.end_u > s.start_u) ? unit_t'(s.end_u - s.start_u) : '0;
   endfunction

   // Remainder of a (FIELD_W+1)-bit value by a nonzero FIELD_W-bit divisor,
   // restoring division, one bit per step.
   function automatic unit_t unit_mod(logic [FIELD_W:0] num, unit_t den);
      logic [FIELD_W:0] rem;
      rem = '0;
      for (int i = FIELD_W; i >= 0; i--) begin
         rem = {rem[FIELD_W-1:0], num[i]};
         if (rem >= {1'b0, den}) rem = rem - {1'b0, den};
      end
      return rem[FIELD_W-1:0];
   endfunction

endpackage

// File: rtl/segwin_cell.sv
module segwin_cell
   import segwin_pkg::*;
#(
   parameter int unsigned RST_START = 0,
   parameter int unsigned RST_END   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  seg_t d,
   output seg_t q
);

   localparam seg_t RST_VAL = '{end_u: unit_t'(RST_END), start_u: unit_t'(RST_START)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= d;
   end

endmodule

// File: rtl/segwin_wrcheck.sv
module segwin_wrcheck
   import segwin_pkg::*;
#(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned CS_W   = 3,
   parameter int unsigned BASE_U = 64,
   parameter int unsigned WIN_U  = 32
) (
   input  logic                   wr_en,
   input  logic [CS_W-1:0]        wr_cs,
   input  logic [31:0]            wr_data,
   input  seg_t [NUM_CS-1:0]      segs,
   output logic                   store,
   output seg_t                   store_val,
   output logic                   fixed,
   output logic                   reject,
   output logic                   misalign,
   output logic                   overlap
);

   localparam logic [9:0] BASE_W = 10'(BASE_U);
   localparam logic [9:0] TOP_W  = 10'(BASE_U + WIN_U);

   logic  cs_ok, same, fix, outside, active, ovl;
   seg_t  cur, req, cand;
   unit_t len;

   always_comb begin
      cs_ok = 1'b0;
      cur   = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (wr_cs == CS_W'(i)) begin
            cs_ok = 1'b1;
            cur   = segs[i];
         end
      end
      req           = wr_data[31:16];
      same          = (req == cur);
      fix           = (wr_cs == '0) && (req.start_u != unit_t'(BASE_U));
      cand.end_u    = req.end_u;
      cand.start_u  = fix ? unit_t'(BASE_U) : req.start_u;
      outside       = ({2'b00, cand.end_u} <= BASE_W) || ({2'b00, cand.start_u} > TOP_W);
      active        = wr_en && cs_ok && !same;
      len           = seg_len(cand);
      ovl           = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if ((wr_cs != CS_W'(i)) &&
             (cand.start_u < segs[i].end_u) && (cand.end_u > segs[i].start_u))
            ovl = 1'b1;
      end
   end

   assign store     = active && !outside;
   assign store_val = cand;
   assign fixed     = active && fix;
   assign reject    = active && outside;
   assign misalign  = store && (len != '0) && (unit_mod({1'b0, cand.start_u}, len) != '0);
   assign overlap   = store && ovl;

endmodule

// File: rtl/segwin_lookup.sv
module segwin_lookup
   import segwin_pkg::*;
#(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned CS_W   = 3
) (
   input  logic [31:0]       addr,
   input  seg_t [NUM_CS-1:0] segs,
   output logic              hit,
   output logic [CS_W-1:0]   cs,
   output logic [31:0]       offset
);

   unit_t au;
   assign au = addr[30:UNIT_LSB];

   // Scan from the top so the lowest matching index is written last.
   always_comb begin
      hit    = 1'b0;
      cs     = '0;
      offset = '0;
      for (int i = NUM_CS - 1; i >= 0; i--) begin
         if (!addr[31] && (au >= segs[i].start_u) && (au < segs[i].end_u)) begin
            hit    = 1'b1;
            cs     = CS_W'(i);
            offset = {1'b0, unit_t'(au - segs[i].start_u), addr[UNIT_LSB-1:0]};
         end
      end
   end

endmodule

// File: rtl/segwin_wrap.sv
module segwin_wrap
   import segwin_pkg::*;
#(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned CS_W   = 3
) (
   input  logic [CS_W-1:0]   acc_cs,
   input  logic [31:0]       acc_offset,
   input  seg_t [NUM_CS-1:0] segs,
   output logic [31:0]       wrapped,
   output logic              oor
);

   unit_t            len;
   logic [FIELD_W:0] units;

   assign units = acc_offset[31:UNIT_LSB];

   always_comb begin
      len = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (acc_cs == CS_W'(i)) len = seg_len(segs[i]);
      end
      if (len == '0) begin
         oor     = 1'b1;
         wrapped = '0;
      end else if (units >= {1'b0, len}) begin
         oor     = 1'b1;
         wrapped = {1'b0, unit_mod(units, len), acc_offset[UNIT_LSB-1:0]};
      end else begin
         oor     = 1'b0;
         wrapped = acc_offset;
      end
   end

endmodule

// File: rtl/segment_window_decoder.sv
module segment_window_decoder
   import segwin_pkg::*;
#(
   parameter int unsigned NUM_CS    = 5,
   parameter int unsigned BASE_U    = 64,
   parameter int unsigned WIN_U     = 32,
   parameter int unsigned CS0_LEN_U = 8,
   parameter int unsigned CSN_LEN_U = 4,
   localparam int unsigned CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CS_W-1:0] wr_cs,
   input  logic [31:0]     wr_data,
   output logic            st_fixed,
   output logic            st_reject,
   output logic            st_misalign,
   output logic            st_overlap,
   input  logic [31:0]     lk_addr,
   output logic            lk_hit,
   output logic [CS_W-1:0] lk_cs,
   output logic [31:0]     lk_offset,
   input  logic [CS_W-1:0] acc_cs,
   input  logic [31:0]     acc_offset,
   output logic [31:0]     acc_wrapped,
   output logic            acc_oor
);

   localparam int unsigned LAST_END_U = BASE_U + CS0_LEN_U + (NUM_CS - 1) * CSN_LEN_U;

   // Elaboration-time parameter checks.
   if (NUM_CS < 1)
      $error("segment_window_decoder: NUM_CS must be at least 1");
   if (BASE_U + WIN_U > 255)
      $error("segment_window_decoder: aperture exceeds the 8-bit unit field");
   if (LAST_END_U > BASE_U + WIN_U)
      $error("segment_window_decoder: default windows exceed the aperture");

   seg_t [NUM_CS-1:0] seg_q;
   logic              store, fix_c, rej_c, mis_c, ovl_c;
   seg_t              store_val;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cell
      localparam int unsigned S_U = (g == 0) ? BASE_U : BASE_U + CS0_LEN_U + (g - 1) * CSN_LEN_U;
      localparam int unsigned E_U = (g == 0) ? BASE_U + CS0_LEN_U : S_U + CSN_LEN_U;
      segwin_cell #(.RST_START(S_U), .RST_END(E_U)) i_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .load (store && (wr_cs == CS_W'(g))),
         .d    (store_val),
         .q    (seg_q[g])
      );
   end

   segwin_wrcheck #(.NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_U(BASE_U), .WIN_U(WIN_U)) i_wrcheck (
      .wr_en    (wr_en),
      .wr_cs    (wr_cs),
      .wr_data  (wr_data),
      .segs     (seg_q),
      .store    (store),
      .store_val(store_val),
      .fixed    (fix_c),
      .reject   (rej_c),
      .misalign (mis_c),
      .overlap  (ovl_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_fixed    <= 1'b0;
         st_reject   <= 1'b0;
         st_misalign <= 1'b0;
         st_overlap  <= 1'b0;
      end else if (wr_en) begin
         st_fixed    <= fix_c;
         st_reject   <= rej_c;
         st_misalign <= mis_c;
         st_overlap  <= ovl_c;
      end
   end

   segwin_lookup #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_lookup (
      .addr  (lk_addr),
      .segs  (seg_q),
      .hit   (lk_hit),
      .cs    (lk_cs),
      .offset(lk_offset)
   );

   segwin_wrap #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_wrap (
      .acc_cs    (acc_cs),
      .acc_offset(acc_offset),
      .segs      (seg_q),
      .wrapped   (acc_wrapped),
      .oor       (acc_oor)
   );

endmodule

// File: rtl/segwin_props.sv
module segwin_props #(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned CS_W   = 3,
   parameter int unsigned BASE_U = 64
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [CS_W-1:0]        wr_cs,
   input logic [31:0]            wr_data,
   input logic                   st_fixed,
   input logic                   st_reject,
   input logic                   st_misalign,
   input logic                   st_overlap,
   input logic                   lk_hit,
   input logic [CS_W-1:0]        lk_cs,
   input logic [31:0]            lk_offset,
   input logic [CS_W-1:0]        acc_cs,
   input logic [31:0]            acc_offset,
   input logic [31:0]            acc_wrapped,
   input logic                   acc_oor,
   input logic [NUM_CS-1:0][15:0] seg_q
);

   logic        wr_valid;
   logic [15:0] wr_held;
   logic [7:0]  lk_len, acc_len;

   always_comb begin
      wr_valid = 1'b0;
      wr_held  = '0;
      lk_len   = '0;
      acc_len  = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (wr_cs == CS_W'(i)) begin
            wr_valid = 1'b1;
            wr_held  = seg_q[i];
         end
         if (lk_cs == CS_W'(i) && seg_q[i][15:8] > seg_q[i][7:0])
            lk_len = seg_q[i][15:8] - seg_q[i][7:0];
         if (acc_cs == CS_W'(i) && seg_q[i][15:8] > seg_q[i][7:0])
            acc_len = seg_q[i][15:8] - seg_q[i][7:0];
      end
   end

   AST_CS0_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      seg_q[0][7:0] == 8'(BASE_U)); // R3

   AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_reject) |-> seg_q == $past(seg_q)); // R4

   AST_REJECT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      st_reject |-> !st_misalign && !st_overlap); // R4

   AST_SAME_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_valid && wr_data[31:16] == wr_held |=>
         seg_q == $past(seg_q) && !st_fixed && !st_reject && !st_misalign && !st_overlap); // R7

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(st_fixed) && $stable(st_reject) && $stable(st_misalign) && $stable(st_overlap)); // R8

   AST_HIT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> !lk_offset[31] && lk_offset[30:23] < lk_len); // R9

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_cs == '0 && lk_offset == '0); // R9

   AST_WRAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_oor |-> acc_wrapped == acc_offset); // R11

   AST_WRAP_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      acc_oor && acc_len != '0 |-> acc_wrapped[31:23] < {1'b0, acc_len}); // R11

endmodule

bind segment_window_decoder segwin_props #(.NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_U(BASE_U)) i_segwin_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_cs      (wr_cs),
   .wr_data    (wr_data),
   .st_fixed   (st_fixed),
   .st_reject  (st_reject),
   .st_misalign(st_misalign),
   .st_overlap (st_overlap),
   .lk_hit     (lk_hit),
   .lk_cs      (lk_cs),
   .lk_offset  (lk_offset),
   .acc_cs     (acc_cs),
   .acc_offset (acc_offset),
   .acc_wrapped(acc_wrapped),
   .acc_oor    (acc_oor),
   .seg_q      (seg_q)
);

// File: tb/test_segment_window_decoder.sv
module test_segment_window_decoder;

   localparam int NCS  = 5;
   localparam int BASE = 64;
   localparam int WIN  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_cs = '0;
   logic [31:0] wr_data = '0;
   logic        st_fixed, st_reject, st_misalign, st_overlap;
   logic [31:0] lk_addr = '0;
   logic        lk_hit;
   logic [2:0]  lk_cs;
   logic [31:0] lk_offset;
   logic [2:0]  acc_cs = '0;
   logic [31:0] acc_offset = '0;
   logic [31:0] acc_wrapped;
   logic        acc_oor;

   int n_chk = 0;
   int n_err = 0;

   // Behavioural model state.
   int ms[NCS];
   int me[NCS];
   int mfix = 0, mrej = 0, mmis = 0, mov = 0;

   always #2 clk = ~clk;

   segment_window_decoder i_segment_window_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .wr_data(wr_data),
      .st_fixed(st_fixed), .st_reject(st_reject), .st_misalign(st_misalign), .st_overlap(st_overlap),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_offset(lk_offset),
      .acc_cs(acc_cs), .acc_offset(acc_offset), .acc_wrapped(acc_wrapped), .acc_oor(acc_oor)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < NCS; i++) begin
         ms[i] = (i == 0) ? BASE : BASE + 8 + (i - 1) * 4;
         me[i] = (i == 0) ? BASE + 8 : ms[i] + 4;
      end
      mfix = 0; mrej = 0; mmis = 0; mov = 0;
   endfunction

   function automatic void model_write(int cs, logic [31:0] d);
      int s, e, len, fx, ov;
      s = int'(d[23:16]);
      e = int'(d[31:24]);
      if (cs >= NCS || (s == ms[cs] && e == me[cs])) begin
         mfix = 0; mrej = 0; mmis = 0; mov = 0;
         return;
      end
      fx = (cs == 0 && s != BASE) ? 1 : 0;
      if (fx != 0) s = BASE;
      if (e <= BASE || s > BASE + WIN) begin
         mfix = fx; mrej = 1; mmis = 0; mov = 0;
         return;
      end
      len = (e > s) ? e - s : 0;
      ov = 0;
      for (int i = 0; i < NCS; i++)
         if (i != cs && s < me[i] && e > ms[i]) ov = 1;
      mfix = fx; mrej = 0;
      mmis = (len != 0 && (s % len) != 0) ? 1 : 0;
      mov = ov;
      ms[cs] = s; me[cs] = e;
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      #1;
      if (rst_n && wr_en) model_write(int'(wr_cs), wr_data);
   end

   // Per-cycle comparison against the model, away from the clock edge.
   always @(negedge clk) begin
      longint a, off, len, eoff;
      int ehit, ecs, nmatch;
      string tg;
      #1;
      chk(st_fixed == mfix[0], rst_n ? "R3" : "R1", "st_fixed", st_fixed, mfix);
      chk(st_reject == mrej[0], rst_n ? "R4" : "R1", "st_reject", st_reject, mrej);
      chk(st_misalign == mmis[0], rst_n ? "R5" : "R1", "st_misalign", st_misalign, mmis);
      chk(st_overlap == mov[0], rst_n ? "R6" : "R1", "st_overlap", st_overlap, mov);
      a = longint'(lk_addr);
      ehit = 0; ecs = 0; eoff = 0; nmatch = 0;
      for (int i = 0; i < NCS; i++) begin
         if (a < 64'h8000_0000 && (a >> 23) >= ms[i] && (a >> 23) < me[i]) begin
            nmatch++;
            if (ehit == 0) begin
               ehit = 1; ecs = i; eoff = a - (longint'(ms[i]) << 23);
            end
         end
      end
      tg = (nmatch > 1) ? "R10" : "R9";
      chk(lk_hit == ehit[0], tg, "lk_hit", lk_hit, ehit);
      chk(int'(lk_cs) == ecs, tg, "lk_cs", lk_cs, ecs);
      chk(longint'(lk_offset) == eoff, tg, "lk_offset", lk_offset, eoff);
      len = (acc_cs < NCS && me[acc_cs] > ms[acc_cs]) ? longint'(me[acc_cs] - ms[acc_cs]) << 23 : 0;
      off = longint'(acc_offset);
      if (len == 0) eoff = 0;
      else if (off >= len) eoff = off % len;
      else eoff = off;
      chk(acc_oor == (len == 0 || off >= len), "R11", "acc_oor", acc_oor, (len == 0 || off >= len));
      chk(longint'(acc_wrapped) == eoff, "R11", "acc_wrapped", acc_wrapped, eoff);
   end

   task automatic do_write(input int cs, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_cs = 3'(cs); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lk(input logic [31:0] addr, input bit h, input int cs,
                     input logic [31:0] off, input string tag);
      @(negedge clk);
      lk_addr = addr;
      #1;
      chk(lk_hit == h && int'(lk_cs) == cs && lk_offset == off, tag, "lookup",
          {lk_hit, 4'(lk_cs), lk_offset}, {h, 4'(cs), off});
   endtask

   task automatic acc(input int cs, input logic [31:0] off, input logic [31:0] w,
                      input bit o, input string tag);
      @(negedge clk);
      acc_cs = 3'(cs); acc_offset = off;
      #1;
      chk(acc_wrapped == w && acc_oor == o, tag, "access",
          {acc_oor, acc_wrapped}, {o, w});
   endtask

   task automatic flags(input bit f, input bit r, input bit m, input bit v, input string tag);
      @(negedge clk);
      #1;
      chk({st_fixed, st_reject, st_misalign, st_overlap} == {f, r, m, v}, tag, "flags",
          {st_fixed, st_reject, st_misalign, st_overlap}, {f, r, m, v});
   endtask

   bit done = 1'b0;

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      flags(0, 0, 0, 0, "R1");
      rst_n = 1'b1;
      // Reset windows
      lk(32'h2000_0000, 1, 0, 32'h0, "R1");
      lk(32'h23FF_FFFF, 1, 0, 32'h03FF_FFFF, "R1");
      lk(32'h2400_0000, 1, 1, 32'h0, "R1");
      lk(32'h2A00_0010, 1, 4, 32'h10, "R1");
      lk(32'h2C00_0000, 0, 0, 32'h0, "R9");
      acc(0, 32'h0400_0000, 32'h0, 1, "R11");
      // Field layout, low bits discarded, overlap
      do_write(2, 32'h5850_ABCD);
      flags(0, 0, 0, 1, "R6");
      lk(32'h2800_0000, 1, 2, 32'h0, "R10");
      lk(32'h2A00_0000, 1, 2, 32'h0200_0000, "R10");
      lk(32'h2600_0000, 0, 0, 32'h0, "R9");
      do_write(2, 32'h5850_0000);
      flags(0, 0, 0, 0, "R2");
      // Chip select 0 start correction
      do_write(0, 32'h4C44_0000);
      flags(1, 0, 1, 1, "R3");
      lk(32'h2400_0000, 1, 0, 32'h0400_0000, "R10");
      acc(0, 32'h0600_0123, 32'h0000_0123, 1, "R11");
      acc(0, 32'h0780_0010, 32'h0180_0010, 1, "R11");
      acc(0, 32'h05FF_FFFF, 32'h05FF_FFFF, 0, "R11");
      // Refusals
      do_write(1, 32'h4030_0000);
      flags(0, 1, 0, 0, "R4");
      acc(1, 32'h0200_0000, 32'h0, 1, "R4");
      do_write(4, 32'h7061_0000);
      flags(0, 1, 0, 0, "R4");
      do_write(4, 32'h6260_0000);
      flags(0, 0, 0, 0, "R4");
      lk(32'h3080_0000, 1, 4, 32'h0080_0000, "R4");
      lk(32'h3100_0000, 0, 0, 32'h0, "R9");
      // Misalignment, then flags hold
      do_write(1, 32'h4B49_0000);
      flags(0, 0, 1, 1, "R5");
      repeat (3) @(negedge clk);
      flags(0, 0, 1, 1, "R8");
      // Zero-length window
      do_write(3, 32'h5454_0000);
      flags(0, 0, 0, 1, "R6");
      acc(3, 32'h5, 32'h0, 1, "R11");
      // Invalid index is a no-op
      do_write(5, 32'h4840_0000);
      flags(0, 0, 0, 0, "R7");
      lk(32'hA000_0000, 0, 0, 32'h0, "R9");
      // Random phase, model compared every cycle
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         wr_en = ($urandom % 3) == 0;
         wr_cs = 3'($urandom % 6);
         if (($urandom % 4) == 0 && wr_cs < NCS)
            wr_data = {8'(me[wr_cs]), 8'(ms[wr_cs]), 16'($urandom)};
         else
            wr_data = {8'(56 + $urandom % 48), 8'(56 + $urandom % 48), 16'($urandom)};
         lk_addr = (($urandom % 8) == 0) ? $urandom : 32'h1C00_0000 + ($urandom % 32'h1800_0000);
         acc_cs = 3'($urandom % 6);
         acc_offset = (($urandom % 2) == 0) ? ($urandom % 32'h0800_0000) : $urandom;
      end
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule